// File: doc/BRIEF.md
# Secure-Aware Interrupt Priority Mask

This block holds the priority threshold for one processor interface. It also gates a single pending interrupt against that threshold. Software programs the threshold through a small register bus. The bus carries a select, a write strobe, an address, write data and a security attribute, and read data comes back one cycle after the request. The threshold is an 8-bit value held in a 32-bit register, and only the low byte is writable. Numerically smaller priorities are more urgent. An interrupt reaches the core only when its priority value is strictly below the threshold.

Two security states can be switched on with a configuration input. When they are on, non-secure software sees a compressed view of the threshold that covers only the less urgent half of the range. Secure software has full access. When secure software has placed the threshold in the more urgent half, non-secure reads return zero and non-secure writes are dropped. A parameter sets how many priority levels are implemented. The unimplemented low bits of the threshold are hard-wired to zero.

Top module: `prio_mask_filter`

## Requirements
- R1: After reset the stored threshold is 0x00, the interrupt output is low and the read data is zero.
- R2: Register bits 31:8 always read as zero, and write data in those bits has no effect.
- R3: With the interrupt valid, the output is high when the incoming priority is numerically less than the stored threshold, and low when the priority is equal to or greater than it.
- R4: With the interrupt not valid, the output is low whatever the incoming priority.
- R5: The output is registered. A threshold write at clock edge N is seen by the filter only from edge N+1, so an interrupt evaluated at edge N uses the old threshold.
- R6: With LEVELS below 256, the low 8-log2(LEVELS) threshold bits read as zero and ignore writes. For example, 32 levels clear bits 2:0.
- R7: A secure access (or any access with the split disabled) writes the byte as it is and reads back the stored byte unchanged.
- R8: A non-secure access with the split enabled and stored bit 7 set works as follows. A write of v stores {1, v[7:1]}, then applies the implemented-bit mask. A read returns {stored[6:0], 0}.
- R9: A non-secure access with the split enabled and stored bit 7 clear works as follows. A read returns zero, and a write leaves the threshold unchanged.
- R10: With split_en low, a non-secure access behaves exactly like a secure access.
- R11: Only address REG_ADDR (default 0x04) is decoded. A read of any other address returns zero, and a write to any other address is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| split_en | input | 1 | Enables the secure/non-secure split |
| bus_sel | input | 1 | Bus request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_secure | input | 1 | 1 = secure access |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data, valid the cycle after a read |
| irq_valid | input | 1 | A pending interrupt is present |
| irq_prio | input | 8 | Priority of the pending interrupt |
| irq_signal | output | 1 | Registered forward-to-core signal |

## Verification
A threshold write and the filter decision for a pending interrupt can fall on the same clock edge. The bench provokes this by holding a valid interrupt whose priority lies between the old and new thresholds while the write is issued. The output must stay low after that edge and rise one edge later. The secure and non-secure views are judged against hand-computed bytes on two instances: one with full levels and one with 32 levels.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam int unsigned PRIO_W = 8;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;

  typedef struct packed {
    acc_kind_e kind;
    logic      restricted;  // non-secure with split active
  } acc_t;

  function automatic int unsigned low_zero_bits(input int unsigned levels);
    return PRIO_W - $clog2(levels);
  endfunction
endpackage

// File: rtl/pm_access_decode.sv
module pm_access_decode #(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h04
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_secure,
  input  logic              split_en,
  output pm_pkg::acc_t      acc
);
  always_comb begin
    acc.kind       = pm_pkg::ACC_NONE;
    acc.restricted = split_en && !bus_secure;
    if (bus_sel && (bus_addr == REG_ADDR)) begin
      acc.kind = bus_wr ? pm_pkg::ACC_WRITE : pm_pkg::ACC_READ;
    end
  end
endmodule

// File: rtl/pm_mask_store.sv
module pm_mask_store #(
  parameter int unsigned LEVELS = 256
) (
  input  logic                      clk,
  input  logic                      rst,
  input  pm_pkg::acc_t              acc,
  input  logic [pm_pkg::PRIO_W-1:0] wdata,
  output logic [pm_pkg::PRIO_W-1:0] mask_q
);
  localparam int unsigned LZ = pm_pkg::low_zero_bits(LEVELS);

  logic                      load;
  logic [pm_pkg::PRIO_W-1:0] next_val;

  // Restricted writes are folded into the less urgent half; locked when
  // the stored value already sits in the more urgent half.
  always_comb begin
    load     = 1'b0;
    next_val = wdata;
    if (acc.kind == pm_pkg::ACC_WRITE) begin
      if (!acc.restricted) begin
        load = 1'b1;
      end else if (mask_q[pm_pkg::PRIO_W-1]) begin
        load     = 1'b1;
        next_val = {1'b1, wdata[pm_pkg::PRIO_W-1:1]};
      end
    end
  end

  for (genvar b = 0; b < pm_pkg::PRIO_W; b++) begin : g_bit
    if (b < LZ) begin : g_tied
      assign mask_q[b] = 1'b0;
    end else begin : g_flop
      logic bit_q;
      always_ff @(posedge clk) begin
        if (rst)       bit_q <= 1'b0;
        else if (load) bit_q <= next_val[b];
      end
      assign mask_q[b] = bit_q;
    end
  end
endmodule

// File: rtl/pm_read_view.sv
module pm_read_view #(
  parameter int unsigned BUS_W = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  pm_pkg::acc_t              acc,
  input  logic [pm_pkg::PRIO_W-1:0] mask_q,
  output logic [BUS_W-1:0]          rdata
);
  logic [pm_pkg::PRIO_W-1:0] view;

  always_comb begin
    if (!acc.restricted)                view = mask_q;
    else if (mask_q[pm_pkg::PRIO_W-1])  view = {mask_q[pm_pkg::PRIO_W-2:0], 1'b0};
    else                                view = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)                               rdata <= '0;
    else if (acc.kind == pm_pkg::ACC_READ) rdata <= BUS_W'(view);
    else                                   rdata <= '0;
  end
endmodule

// File: rtl/pm_prio_filter.sv
module pm_prio_filter (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      irq_valid,
  input  logic [pm_pkg::PRIO_W-1:0] irq_prio,
  input  logic [pm_pkg::PRIO_W-1:0] mask_q,
  output logic                      irq_signal
);
  always_ff @(posedge clk) begin
    if (rst) irq_signal <= 1'b0;
    else     irq_signal <= irq_valid && (irq_prio < mask_q);
  end
endmodule

// File: rtl/prio_mask_filter.sv
module prio_mask_filter #(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h04,
  parameter int unsigned BUS_W = 32,
  parameter int unsigned LEVELS = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              split_en,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_secure,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              irq_valid,
  input  logic [7:0]        irq_prio,
  output logic              irq_signal
);
  localparam int unsigned PW = pm_pkg::PRIO_W;

  pm_pkg::acc_t  acc;
  logic [PW-1:0] mask_q;
  logic          unused_hi;

  assign unused_hi = ^bus_wdata[BUS_W-1:PW];

  pm_access_decode #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_dec (
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_secure(bus_secure), .split_en(split_en), .acc(acc)
  );

  pm_mask_store #(.LEVELS(LEVELS)) u_store (
    .clk(clk), .rst(rst), .acc(acc), .wdata(bus_wdata[PW-1:0]), .mask_q(mask_q)
  );

  pm_read_view #(.BUS_W(BUS_W)) u_view (
    .clk(clk), .rst(rst), .acc(acc), .mask_q(mask_q), .rdata(bus_rdata)
  );

  pm_prio_filter u_filt (
    .clk(clk), .rst(rst), .irq_valid(irq_valid), .irq_prio(irq_prio),
    .mask_q(mask_q), .irq_signal(irq_signal)
  );
endmodule

// File: rtl/pm_checker.sv
module pm_checker #(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h04,
  parameter int unsigned BUS_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              split_en,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_secure,
  input logic [BUS_W-1:0]  bus_rdata,
  input logic              irq_valid,
  input logic [7:0]        irq_prio,
  input logic              irq_signal,
  input logic [7:0]        mask_q
);
  logic hit, ns;
  assign hit = bus_sel && (bus_addr == REG_ADDR);
  assign ns  = split_en && !bus_secure;

  p_fwd_r3: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && (irq_prio < mask_q)) |=> irq_signal);
  p_strict_r3: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && (irq_prio >= mask_q)) |=> !irq_signal);
  p_idle_low_r4: assert property (@(posedge clk) disable iff (rst)
    !irq_valid |=> !irq_signal);
  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_wr) |=> (bus_rdata[BUS_W-1:8] == '0));
  p_ns_floor_r8: assert property (@(posedge clk) disable iff (rst)
    (hit && bus_wr && ns && mask_q[7]) |=> mask_q[7]);
  p_ns_lock_r9: assert property (@(posedge clk) disable iff (rst)
    (hit && bus_wr && ns && !mask_q[7]) |=> $stable(mask_q));
  p_ns_hide_r9: assert property (@(posedge clk) disable iff (rst)
    (hit && !bus_wr && ns && !mask_q[7]) |=> (bus_rdata == '0));
  p_off_addr_r11: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !hit) |=> (bus_rdata == '0) && $stable(mask_q));
endmodule

bind prio_mask_filter pm_checker #(
  .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .BUS_W(BUS_W)
) u_chk (
  .clk(clk), .rst(rst), .split_en(split_en), .bus_sel(bus_sel),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_secure(bus_secure),
  .bus_rdata(bus_rdata), .irq_valid(irq_valid), .irq_prio(irq_prio),
  .irq_signal(irq_signal), .mask_q(mask_q)
);

// File: tb/sim_prio_mask_filter.sv
module sim_prio_mask_filter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        split_en = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic        bus_secure = 1'b1;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata0, rdata1;
  logic        irq_valid = 1'b0;
  logic [7:0]  irq_prio = 8'h00;
  logic        irq0, irq1;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  prio_mask_filter u0 (
    .clk(clk), .rst(rst), .split_en(split_en), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_secure(bus_secure), .bus_wdata(bus_wdata),
    .bus_rdata(rdata0), .irq_valid(irq_valid), .irq_prio(irq_prio), .irq_signal(irq0)
  );

  prio_mask_filter #(.LEVELS(32)) u1 (
    .clk(clk), .rst(rst), .split_en(split_en), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_secure(bus_secure), .bus_wdata(bus_wdata),
    .bus_rdata(rdata1), .irq_valid(irq_valid), .irq_prio(irq_prio), .irq_signal(irq1)
  );

  // {op:4 (1=write), secure:4, req:8, addr:8, data:32 (write data or expected read)}
  localparam int NV = 15;
  localparam logic [55:0] VEC [NV] = '{
    56'h0_1_01_04_00000000,  // R1 reset value
    56'h1_1_02_04_DEADBEA5,
    56'h0_1_02_04_000000A5,  // R2 upper bits dropped, R7 secure view
    56'h0_0_08_04_0000004A,  // R8 folded read
    56'h1_0_08_04_00000030,
    56'h0_1_08_04_00000098,  // R8 folded write
    56'h0_0_08_04_00000030,
    56'h1_1_07_04_00000040,
    56'h0_1_07_04_00000040,  // R7
    56'h0_0_09_04_00000000,  // R9 hidden
    56'h1_0_09_04_000000FE,
    56'h0_1_09_04_00000040,  // R9 write dropped
    56'h1_1_0B_08_00000011,
    56'h0_1_0B_08_00000000,  // R11 other address reads zero
    56'h0_1_0B_04_00000040   // R11 other address write ignored
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_cycle(input logic wr, input logic sec, input logic [7:0] addr,
                           input logic [31:0] data);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = wr; bus_secure = sec; bus_addr = addr; bus_wdata = data;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic irq_step(input logic v, input logic [7:0] p);
    @(negedge clk);
    irq_valid = v; irq_prio = p;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R11 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 irq after reset", {31'b0, irq0}, 32'h0);
    check("R1 rdata after reset", rdata0, 32'h0);

    for (int i = 0; i < NV; i++) begin
      bus_cycle(VEC[i][55:52] != 0, VEC[i][51:48] != 0, VEC[i][39:32], VEC[i][31:0]);
      if (VEC[i][55:52] == 0)
        check($sformatf("R%0d table row %0d", VEC[i][47:40], i), rdata0, VEC[i][31:0]);
    end

    // Threshold is 0x40 now.
    irq_step(1'b1, 8'h3F); check("R3 below threshold", {31'b0, irq0}, 32'h1);
    irq_step(1'b1, 8'h40); check("R3 equal threshold", {31'b0, irq0}, 32'h0);
    irq_step(1'b1, 8'h41); check("R3 above threshold", {31'b0, irq0}, 32'h0);
    irq_step(1'b0, 8'h00); check("R4 not valid", {31'b0, irq0}, 32'h0);

    // R5: write 0x60 on the same edge that evaluates priority 0x50.
    @(negedge clk);
    irq_valid = 1'b1; irq_prio = 8'h50;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_secure = 1'b1; bus_addr = 8'h04; bus_wdata = 32'h60;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0;
    check("R5 old threshold used", {31'b0, irq0}, 32'h0);
    @(posedge clk);
    @(negedge clk);
    check("R5 new threshold used", {31'b0, irq0}, 32'h1);
    irq_valid = 1'b0;

    // R10: split off, non-secure acts as secure even with bit 7 clear.
    split_en = 1'b0;
    bus_cycle(1'b1, 1'b0, 8'h04, 32'h22);
    bus_cycle(1'b0, 1'b0, 8'h04, 32'h0);
    check("R10 split off read", rdata0, 32'h22);
    check("R6 split off 32 levels", rdata1, 32'h20);
    split_en = 1'b1;

    // R6: 32 levels tie bits 2:0 low.
    bus_cycle(1'b1, 1'b1, 8'h04, 32'hFF);
    bus_cycle(1'b0, 1'b1, 8'h04, 32'h0);
    check("R7 full levels", rdata0, 32'hFF);
    check("R6 32 levels secure", rdata1, 32'hF8);
    bus_cycle(1'b1, 1'b0, 8'h04, 32'h0F);
    bus_cycle(1'b0, 1'b1, 8'h04, 32'h0);
    check("R8 full levels folded", rdata0, 32'h87);
    check("R6 32 levels folded", rdata1, 32'h80);

    // R1: reset again with a valid, most urgent interrupt present.
    @(negedge clk);
    rst = 1'b1; irq_valid = 1'b1; irq_prio = 8'h00;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 irq during reset", {31'b0, irq0}, 32'h0);
    bus_cycle(1'b0, 1'b1, 8'h04, 32'h0);
    check("R1 threshold cleared", rdata0, 32'h0);
    check("R1 masks all interrupts", {31'b0, irq0}, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule